// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing register window of a real-time clock. A byte-wide bus sees two addresses: the even one loads a pointer, and the odd one reads or writes the byte that the pointer selects in a 128-entry store. Most entries are plain storage held in a small RAM. Seven entries hold the calendar time in flops, so that a separate timekeeper can see them in parallel. Four entries (0x0A to 0x0D) are control and status registers with their own access rules: a write-protected update-in-progress bit, a read-to-clear flag register, and a read-only register.

The timekeeper and the periodic generator sit outside this block. They connect through single-cycle event inputs (update begin, update end, periodic tick, alarm match) and through a parallel time bus. The timekeeper writes new time values in over that bus. This block tells it, with a one-cycle strobe, when software has changed the time entries and the counter must reload. The block also owns the interrupt line, and it applies the power-on defaults and the lighter system-reset rules.

Top module: `rtc_idx_port`

## Requirements
- R1: A write to the even address (`bus_addr`=0) loads the pointer from `bus_wdata[6:0]`; bit 7 is dropped. A read of the even address returns 0xFF.
- R2: A read of the odd address returns the selected entry in the same cycle as `bus_rd`. A write of the odd address stores the byte in every entry except 0x0A to 0x0D, which follow R3 to R5.
- R3: A write to entry 0x0A replaces bits 6:0 and leaves bit 7 (update in progress, UIP) as it was.
- R4: A write to entry 0x0B stores all eight bits. If written bit 7 (SET) is 1, UIP in 0x0A is cleared on the same edge.
- R5: Writes to entries 0x0C and 0x0D have no effect.
- R6: A read of entry 0x0C returns its current value, then clears it to 0x00 and drops `irq_o`. Flags raised by an event in that same cycle survive the clear.
- R7: A periodic tick with 0x0B bit 6 set raises 0x0C bits 7 and 6 and `irq_o`. An alarm match with 0x0B bit 5 set raises 0x0C bits 7 and 5 and `irq_o`. When the enable bit is clear, the event changes nothing.
- R8: Update end always sets 0x0C bit 4 and clears UIP. With 0x0B bit 4 set, it also sets 0x0C bit 7 and raises `irq_o`. Update begin sets UIP only while SET is 0.
- R9: Power-on reset gives 0x0A=0x26, 0x0B=0x02, 0x0C=0x00, 0x0D=0x80, pointer 0, time entries 0x00 and `irq_o` low.
- R10: System reset clears 0x0B bits 6, 5 and 3, clears 0x0C and drops `irq_o`. It keeps 0x0A, 0x0D and all stored entries.
- R11: Time entries are 0x00, 0x02, 0x04, 0x06, 0x07, 0x08 and 0x09. They appear on `time_regs` in that order from bit 0 upward, one byte each. A bus write to one of them while SET is 0 pulses `time_load` for one cycle after the write edge. While SET is 1, the byte is stored and there is no pulse.
- R12: A write to 0x0B that takes SET from 1 to 0 pulses `time_load` in the cycle after the write.
- R13: `tk_wr` loads all seven time entries from `tk_time` (same packing as R11) while SET is 0. While SET is 1, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| srst | input | 1 | Synchronous system reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| evt_upd_begin | input | 1 | Timekeeper starts an update |
| evt_upd_end | input | 1 | Timekeeper finished an update |
| evt_periodic | input | 1 | Periodic tick |
| evt_alarm | input | 1 | Alarm match |
| tk_wr | input | 1 | Timekeeper writes the time entries |
| tk_time | input | 56 | New time entries, packed as in R11 |
| time_regs | output | 56 | Current time entries, packed as in R11 |
| time_load | output | 1 | One-cycle strobe: reload the counter from `time_regs` |
| ctl_a | output | 8 | Contents of entry 0x0A |
| ctl_b | output | 8 | Contents of entry 0x0B |
| irq_o | output | 1 | Interrupt request |

## Verification
Random pointer loads, data writes and reads over the whole index range are compared against a bench model. This shows whether each index is routed to the right store: RAM, time flops or control registers. Directed sequences cover the cases where the rules interact. They fire each event with its enable on and with it off, to separate the flag gating from the flag setting. They read 0x0C in the same cycle as a periodic tick, to show that a new flag beats the clear. They toggle SET around time writes, so that a missing or extra reload strobe is caught. They apply the system reset with every enable set, to separate the bits that reset clears from those it keeps.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned IW = 7;
  localparam int unsigned NT = 7;
  localparam int unsigned SW = $clog2(NT);

  typedef logic [IW-1:0] idx_t;
  typedef logic [DW-1:0] byte_t;

  localparam idx_t IDX_A = 7'h0A;
  localparam idx_t IDX_B = 7'h0B;
  localparam idx_t IDX_C = 7'h0C;
  localparam idx_t IDX_D = 7'h0D;

  localparam int unsigned A_UIP  = 7;
  localparam int unsigned B_SET  = 7;
  localparam int unsigned B_PIE  = 6;
  localparam int unsigned B_AIE  = 5;
  localparam int unsigned B_UIE  = 4;
  localparam int unsigned B_SQW  = 3;
  localparam int unsigned C_IRQF = 7;
  localparam int unsigned C_PF   = 6;
  localparam int unsigned C_AF   = 5;
  localparam int unsigned C_UF   = 4;

  localparam byte_t A_POR   = 8'h26;
  localparam byte_t B_POR   = 8'h02;
  localparam byte_t D_POR   = 8'h80;
  localparam byte_t PTR_RD  = 8'hFF;

  function automatic logic is_time(idx_t i);
    case (i)
      7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [SW-1:0] time_slot(idx_t i);
    case (i)
      7'h02:   return SW'(1);
      7'h04:   return SW'(2);
      7'h06:   return SW'(3);
      7'h07:   return SW'(4);
      7'h08:   return SW'(5);
      7'h09:   return SW'(6);
      default: return SW'(0);
    endcase
  endfunction

  function automatic logic is_ctrl(idx_t i);
    return (i == IDX_A) || (i == IDX_B) || (i == IDX_C) || (i == IDX_D);
  endfunction
endpackage

// File: rtl/rtc_gp_ram.sv
module rtc_gp_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read: distributed RAM, data in the strobe cycle
  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned NT = 7,
  parameter int unsigned SW = $clog2(NT)
) (
  input  logic             clk,
  input  logic             por,
  input  logic             bus_we,
  input  logic [SW-1:0]    bus_slot,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             tk_we,
  input  logic [NT*DW-1:0] tk_data,
  output logic [NT*DW-1:0] q
);
  logic [DW-1:0] slot_q [NT];

  for (genvar g = 0; g < NT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (por)
        slot_q[g] <= '0;
      else if (bus_we && (bus_slot == SW'(g)))
        slot_q[g] <= bus_wdata;
      else if (tk_we)
        slot_q[g] <= tk_data[g*DW +: DW];
    end
    assign q[g*DW +: DW] = slot_q[g];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_idx_pkg::*;
(
  input  logic  clk,
  input  logic  por,
  input  logic  srst,
  input  logic  wr_a,
  input  logic  wr_b,
  input  logic  rd_c,
  input  byte_t wdata,
  input  logic  evt_upd_begin,
  input  logic  evt_upd_end,
  input  logic  evt_periodic,
  input  logic  evt_alarm,
  output byte_t reg_a,
  output byte_t reg_b,
  output byte_t reg_c,
  output byte_t reg_d,
  output logic  irq,
  output logic  set_fall
);
  localparam byte_t B_RST_MASK = byte_t'((1 << B_PIE) | (1 << B_AIE) | (1 << B_SQW));

  byte_t a_nx, b_nx, c_nx, new_flags;
  logic  irq_nx;

  always_comb begin
    a_nx = wr_a ? {reg_a[A_UIP], wdata[DW-2:0]} : reg_a;
    if (wr_b && wdata[B_SET])                   a_nx[A_UIP] = 1'b0;
    else if (evt_upd_end)                       a_nx[A_UIP] = 1'b0;
    else if (evt_upd_begin && !reg_b[B_SET])    a_nx[A_UIP] = 1'b1;

    b_nx = wr_b ? wdata : reg_b;

    new_flags = '0;
    if (evt_periodic && reg_b[B_PIE]) begin
      new_flags[C_PF]   = 1'b1;
      new_flags[C_IRQF] = 1'b1;
    end
    if (evt_alarm && reg_b[B_AIE]) begin
      new_flags[C_AF]   = 1'b1;
      new_flags[C_IRQF] = 1'b1;
    end
    if (evt_upd_end) begin
      new_flags[C_UF] = 1'b1;
      if (reg_b[B_UIE]) new_flags[C_IRQF] = 1'b1;
    end

    c_nx   = (rd_c ? '0 : reg_c) | new_flags;
    irq_nx = new_flags[C_IRQF] ? 1'b1 : (rd_c ? 1'b0 : irq);
  end

  assign set_fall = wr_b && reg_b[B_SET] && !wdata[B_SET];

  always_ff @(posedge clk) begin
    if (por) begin
      reg_a <= A_POR;
      reg_b <= B_POR;
      reg_c <= '0;
      reg_d <= D_POR;
      irq   <= 1'b0;
    end else if (srst) begin
      reg_b <= reg_b & ~B_RST_MASK;
      reg_c <= '0;
      irq   <= 1'b0;
    end else begin
      reg_a <= a_nx;
      reg_b <= b_nx;
      reg_c <= c_nx;
      irq   <= irq_nx;
    end
  end
endmodule

// File: rtl/rtc_idx_port.sv
module rtc_idx_port
  import rtc_idx_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             srst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             evt_upd_begin,
  input  logic             evt_upd_end,
  input  logic             evt_periodic,
  input  logic             evt_alarm,
  input  logic             tk_wr,
  input  logic [NT*DW-1:0] tk_time,
  output logic [NT*DW-1:0] time_regs,
  output logic             time_load,
  output logic [DW-1:0]    ctl_a,
  output logic [DW-1:0]    ctl_b,
  output logic             irq_o
);
  idx_t          idx_q;
  logic          wr_data, rd_data, hit_time, hit_ctrl;
  logic          wr_time, wr_gp, wr_a, wr_b, rd_c, set_fall;
  logic [SW-1:0] slot;
  byte_t         reg_a, reg_b, reg_c, reg_d, ram_q;

  assign wr_data  = bus_wr && bus_addr;
  assign rd_data  = bus_rd && bus_addr;
  assign hit_time = is_time(idx_q);
  assign hit_ctrl = is_ctrl(idx_q);
  assign slot     = time_slot(idx_q);
  assign wr_time  = wr_data && hit_time;
  assign wr_gp    = wr_data && !hit_time && !hit_ctrl;
  assign wr_a     = wr_data && (idx_q == IDX_A);
  assign wr_b     = wr_data && (idx_q == IDX_B);
  assign rd_c     = rd_data && (idx_q == IDX_C);

  // pointer register
  always_ff @(posedge clk) begin
    if (por)
      idx_q <= '0;
    else if (bus_wr && !bus_addr)
      idx_q <= bus_wdata[IW-1:0];
  end

  // reload strobe for the external counter
  always_ff @(posedge clk) begin
    if (por || srst)
      time_load <= 1'b0;
    else
      time_load <= (wr_time && !reg_b[B_SET]) || set_fall;
  end

  rtc_gp_ram #(.DW(DW), .AW(IW)) u_ram (
    .clk   (clk),
    .we    (wr_gp),
    .waddr (idx_q),
    .wdata (bus_wdata),
    .raddr (idx_q),
    .rdata (ram_q)
  );

  rtc_time_bank #(.DW(DW), .NT(NT), .SW(SW)) u_time (
    .clk       (clk),
    .por       (por),
    .bus_we    (wr_time),
    .bus_slot  (slot),
    .bus_wdata (bus_wdata),
    .tk_we     (tk_wr && !reg_b[B_SET]),
    .tk_data   (tk_time),
    .q         (time_regs)
  );

  rtc_ctrl_regs u_ctrl (
    .clk           (clk),
    .por           (por),
    .srst          (srst),
    .wr_a          (wr_a),
    .wr_b          (wr_b),
    .rd_c          (rd_c),
    .wdata         (bus_wdata),
    .evt_upd_begin (evt_upd_begin),
    .evt_upd_end   (evt_upd_end),
    .evt_periodic  (evt_periodic),
    .evt_alarm     (evt_alarm),
    .reg_a         (reg_a),
    .reg_b         (reg_b),
    .reg_c         (reg_c),
    .reg_d         (reg_d),
    .irq           (irq_o),
    .set_fall      (set_fall)
  );

  // read mux, combinational so data is valid with the strobe
  always_comb begin
    if (!bus_addr)
      bus_rdata = PTR_RD;
    else if (hit_time)
      bus_rdata = time_regs[slot*DW +: DW];
    else begin
      case (idx_q)
        IDX_A:   bus_rdata = reg_a;
        IDX_B:   bus_rdata = reg_b;
        IDX_C:   bus_rdata = reg_c;
        IDX_D:   bus_rdata = reg_d;
        default: bus_rdata = ram_q;
      endcase
    end
  end

  assign ctl_a = reg_a;
  assign ctl_b = reg_b;
endmodule

// File: rtl/rtc_idx_port_chk.sv
module rtc_idx_port_chk
  import rtc_idx_pkg::*;
(
  input logic    clk,
  input logic    por,
  input logic    srst,
  input logic    bus_wr,
  input logic    bus_rd,
  input logic    bus_addr,
  input byte_t   bus_wdata,
  input idx_t    idx,
  input byte_t   ctl_a,
  input byte_t   ctl_b,
  input logic    irq_o,
  input logic    time_load,
  input logic    evt_upd_begin,
  input logic    evt_upd_end,
  input logic    evt_periodic,
  input logic    evt_alarm
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (por || srst)
    (bus_wr && !bus_addr) |=> (idx == $past(bus_wdata[IW-1:0])));

  a_r3_uip_kept: assert property (@(posedge clk) disable iff (por || srst)
    (bus_wr && bus_addr && idx == IDX_A && !evt_upd_begin && !evt_upd_end)
    |=> (ctl_a == {$past(ctl_a[A_UIP]), $past(bus_wdata[DW-2:0])}));

  a_r4_set_clears_uip: assert property (@(posedge clk) disable iff (por || srst)
    (bus_wr && bus_addr && idx == IDX_B && bus_wdata[B_SET]) |=> !ctl_a[A_UIP]);

  a_r6_read_c_drops_irq: assert property (@(posedge clk) disable iff (por || srst)
    (bus_rd && bus_addr && idx == IDX_C && !evt_periodic && !evt_alarm && !evt_upd_end)
    |=> !irq_o);

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (por || srst)
    $rose(irq_o) |-> $past(evt_periodic || evt_alarm || evt_upd_end));

  a_r11_load_after_write: assert property (@(posedge clk) disable iff (por || srst)
    time_load |-> $past(bus_wr && bus_addr));

  a_r9_por_defaults: assert property (@(posedge clk) disable iff (srst)
    por |=> (ctl_a == A_POR && ctl_b == B_POR && !irq_o));
endmodule

bind rtc_idx_port rtc_idx_port_chk u_chk (
  .clk           (clk),
  .por           (por),
  .srst          (srst),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .idx           (idx_q),
  .ctl_a         (ctl_a),
  .ctl_b         (ctl_b),
  .irq_o         (irq_o),
  .time_load     (time_load),
  .evt_upd_begin (evt_upd_begin),
  .evt_upd_end   (evt_upd_end),
  .evt_periodic  (evt_periodic),
  .evt_alarm     (evt_alarm)
);

// File: tb/tb_rtc_idx_port.sv
module tb_rtc_idx_port;
  logic        clk = 1'b0;
  logic        por = 1'b1, srst = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        evt_upd_begin = 1'b0, evt_upd_end = 1'b0, evt_periodic = 1'b0, evt_alarm = 1'b0;
  logic        tk_wr = 1'b0;
  logic [55:0] tk_time = '0;
  logic [55:0] time_regs;
  logic        time_load;
  logic [7:0]  ctl_a, ctl_b;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  // bench model
  logic [7:0] m_mem [128];
  bit         m_vld [128];
  logic [7:0] m_a, m_b, m_c, m_d;
  logic [6:0] m_idx;

  always #2 clk = ~clk;

  rtc_idx_port dut (
    .clk(clk), .por(por), .srst(srst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_upd_begin(evt_upd_begin), .evt_upd_end(evt_upd_end),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .tk_wr(tk_wr), .tk_time(tk_time), .time_regs(time_regs),
    .time_load(time_load), .ctl_a(ctl_a), .ctl_b(ctl_b), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_at(input logic [6:0] i, output logic [7:0] d);
    wr(1'b0, {1'b0, i});
    rd(1'b1, d);
  endtask

  task automatic wr_at(input logic [6:0] i, input logic [7:0] d);
    wr(1'b0, {1'b0, i});
    wr(1'b1, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_upd_begin = 1'b1;
      1: evt_upd_end   = 1'b1;
      2: evt_periodic  = 1'b1;
      default: evt_alarm = 1'b1;
    endcase
    @(negedge clk);
    evt_upd_begin = 1'b0; evt_upd_end = 1'b0; evt_periodic = 1'b0; evt_alarm = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por = 1'b1;
    @(negedge clk); @(negedge clk); por = 1'b0;
  endtask

  function automatic bit is_tm(logic [6:0] i);
    return i inside {7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09};
  endfunction

  function automatic logic [7:0] exp_rd(logic [6:0] i);
    case (i)
      7'h0A: return m_a;
      7'h0B: return m_b;
      7'h0C: return m_c;
      7'h0D: return m_d;
      default: return m_mem[i];
    endcase
  endfunction

  function automatic void model_wr(logic [6:0] i, logic [7:0] d);
    case (i)
      7'h0A: m_a = {m_a[7], d[6:0]};
      7'h0B: begin if (d[7]) m_a[7] = 1'b0; m_b = d; end
      7'h0C, 7'h0D: ;
      default: begin m_mem[i] = d; m_vld[i] = 1'b1; end
    endcase
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));

    // R9 power-on defaults
    do_por();
    rd(1'b1, d); chk(d == 8'h00, "R9 index0 time entry", d, 8'h00);
    rd_at(7'h0A, d); chk(d == 8'h26, "R9 reg A", d, 8'h26);
    rd_at(7'h0B, d); chk(d == 8'h02, "R9 reg B", d, 8'h02);
    rd_at(7'h0C, d); chk(d == 8'h00, "R9 reg C", d, 8'h00);
    rd_at(7'h0D, d); chk(d == 8'h80, "R9 reg D", d, 8'h80);
    chk(irq_o == 1'b0, "R9 irq low", irq_o, 0);
    chk(time_regs == '0, "R9 time zero", time_regs, 0);

    // R1 pointer port
    rd(1'b0, d); chk(d == 8'hFF, "R1 even read", d, 8'hFF);
    wr(1'b0, 8'h8A); rd(1'b1, d); chk(d == 8'h26, "R1 bit7 dropped", d, 8'h26);

    // R5 read-only C and D
    wr_at(7'h0C, 8'hFF); rd(1'b1, d); chk(d == 8'h00, "R5 C write ignored", d, 8'h00);
    wr_at(7'h0D, 8'h00); rd(1'b1, d); chk(d == 8'h80, "R5 D write ignored", d, 8'h80);

    // R3 / R4 / R8 UIP handling
    wr_at(7'h0A, 8'hDF); rd(1'b1, d); chk(d == 8'h5F, "R3 UIP kept 0", d, 8'h5F);
    pulse(0); rd(1'b1, d); chk(d == 8'hDF, "R8 begin sets UIP", d, 8'hDF);
    wr(1'b1, 8'h26); rd(1'b1, d); chk(d == 8'hA6, "R3 UIP kept 1", d, 8'hA6);
    wr_at(7'h0B, 8'h82); rd_at(7'h0A, d); chk(d == 8'h26, "R4 SET clears UIP", d, 8'h26);
    pulse(0); rd(1'b1, d); chk(d == 8'h26, "R8 begin blocked by SET", d, 8'h26);
    wr_at(7'h0B, 8'h02);
    chk(time_load == 1'b1, "R12 SET fall reload", time_load, 1);
    pulse(0); pulse(1); rd_at(7'h0A, d); chk(d == 8'h26, "R8 end clears UIP", d, 8'h26);

    // R8 update flag without enable, R6 clear on read
    chk(irq_o == 1'b0, "R8 no irq without UIE", irq_o, 0);
    rd_at(7'h0C, d); chk(d == 8'h10, "R8 UF set", d, 8'h10);
    rd(1'b1, d); chk(d == 8'h00, "R6 C cleared by read", d, 8'h00);
    wr_at(7'h0B, 8'h12); pulse(1);
    chk(irq_o == 1'b1, "R8 irq with UIE", irq_o, 1);
    rd_at(7'h0C, d); chk(d == 8'h90, "R8 C with UIE", d, 8'h90);
    chk(irq_o == 1'b0, "R6 irq dropped", irq_o, 0);

    // R7 periodic / alarm gating
    wr_at(7'h0B, 8'h42); pulse(2);
    chk(irq_o == 1'b1, "R7 periodic irq", irq_o, 1);
    rd_at(7'h0C, d); chk(d == 8'hC0, "R7 periodic flags", d, 8'hC0);
    wr_at(7'h0B, 8'h02); pulse(3); pulse(2);
    chk(irq_o == 1'b0, "R7 disabled no irq", irq_o, 0);
    rd_at(7'h0C, d); chk(d == 8'h00, "R7 disabled no flags", d, 8'h00);
    wr_at(7'h0B, 8'h22); pulse(3);
    rd_at(7'h0C, d); chk(d == 8'hA0, "R7 alarm flags", d, 8'hA0);

    // R6 event in the read cycle survives
    wr_at(7'h0B, 8'h42); wr(1'b0, 8'h0C);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 1'b1; evt_periodic = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; evt_periodic = 1'b0;
    chk(d == 8'h00, "R6 old value returned", d, 8'h00);
    chk(irq_o == 1'b1, "R6 new irq survives", irq_o, 1);
    rd(1'b1, d); chk(d == 8'hC0, "R6 new flags survive", d, 8'hC0);

    // R10 system reset
    wr_at(7'h20, 8'h5A);
    wr_at(7'h0B, 8'h7A); pulse(2);
    @(negedge clk); srst = 1'b1; @(negedge clk); srst = 1'b0;
    chk(irq_o == 1'b0, "R10 irq cleared", irq_o, 0);
    rd_at(7'h0B, d); chk(d == 8'h12, "R10 B enables cleared", d, 8'h12);
    rd_at(7'h0C, d); chk(d == 8'h00, "R10 C cleared", d, 8'h00);
    rd_at(7'h0A, d); chk(d == 8'h26, "R10 A kept", d, 8'h26);
    rd_at(7'h20, d); chk(d == 8'h5A, "R10 entry kept", d, 8'h5A);

    // R11 time writes and reload strobe
    wr_at(7'h0B, 8'h02);
    wr_at(7'h04, 8'h23);
    chk(time_load == 1'b1, "R11 load pulse", time_load, 1);
    chk(time_regs[23:16] == 8'h23, "R11 slot of entry 4", time_regs[23:16], 8'h23);
    @(negedge clk); chk(time_load == 1'b0, "R11 pulse one cycle", time_load, 0);
    wr_at(7'h01, 8'h77); chk(time_load == 1'b0, "R11 no pulse non-time", time_load, 0);
    wr_at(7'h0B, 8'h82); chk(time_load == 1'b0, "R12 no pulse on SET rise", time_load, 0);
    wr_at(7'h07, 8'h15); chk(time_load == 1'b0, "R11 no pulse under SET", time_load, 0);
    chk(time_regs[39:32] == 8'h15, "R11 stored under SET", time_regs[39:32], 8'h15);
    wr_at(7'h0B, 8'h02); chk(time_load == 1'b1, "R12 pulse on SET fall", time_load, 1);

    // R13 timekeeper writes
    @(negedge clk); tk_wr = 1'b1; tk_time = 56'h11_22_33_44_55_66_77;
    @(negedge clk); tk_wr = 1'b0;
    chk(time_regs == 56'h11_22_33_44_55_66_77, "R13 tk load", time_regs, 56'h11_22_33_44_55_66_77);
    rd_at(7'h09, d); chk(d == 8'h11, "R13 entry 9 via bus", d, 8'h11);
    wr_at(7'h0B, 8'h82);
    @(negedge clk); tk_wr = 1'b1; tk_time = 56'hAA_BB_CC_DD_EE_FF_01;
    @(negedge clk); tk_wr = 1'b0;
    rd_at(7'h00, d); chk(d == 8'h77, "R13 ignored under SET", d, 8'h77);

    // random phase, R2 routing
    do_por();
    m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_d = 8'h80; m_idx = '0;
    for (int i = 0; i < 128; i++) begin
      m_mem[i] = 8'h00; m_vld[i] = is_tm(7'(i));
    end
    for (int k = 0; k < 600; k++) begin
      int op = $urandom % 4;
      logic [7:0] r = 8'($urandom);
      case (op)
        0: begin
          logic [7:0] v = ($urandom % 2) ? {r[7:4] & 4'h8, r[3:0]} : r;
          wr(1'b0, v); m_idx = v[6:0];
        end
        1: begin wr(1'b1, r); model_wr(m_idx, r); end
        2: begin
          rd(1'b1, d);
          if (m_vld[m_idx] || m_idx inside {[7'h0A:7'h0D]})
            chk(d == exp_rd(m_idx), "R2 random read", d, exp_rd(m_idx));
          if (m_idx == 7'h0C) m_c = 8'h00;
        end
        default: begin rd(1'b0, d); chk(d == 8'hFF, "R1 random even read", d, 8'hFF); end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule